// File: doc/BRIEF.md
# Blind Oversampling Bit Recovery

This block recovers a serial bit stream from a line that arrives without any clock of its own. A local clock runs at a fixed integer multiple of the nominal bit rate. The line is first brought into that clock domain, and then every transition is located relative to a free-running bit timer. Once per window of bit periods, the block finds the timer position where transitions occur most often and moves its sampling instant one clock toward the point half a bit away from that position.

The sampling instant is a bit timer that normally reloads every `OVS` clocks. A phase step lengthens or shortens exactly one bit period by one clock. For this reason a phase that drifts past the end of the timer range never produces a duplicated or a missing bit: each transmitted bit yields exactly one strobe. Each recovered bit is presented with a one-clock valid strobe.

An error flag reports a line that carries no usable stream. This covers a line that stays quiet for too long, and transitions scattered over too many timer positions to define a bit boundary.

Top module: `cdr_blind_os`

## Requirements
- R1: While `rst_n` is low, `bit_out`, `bit_vld` and `err` are all 0.
- R2: For a stream whose bits each last exactly `OVS` clocks, once the block is locked, `bit_vld` is high on exactly one clock in every `OVS` (20 strobes in 100 clocks for `OVS` = 5).
- R3: `bit_vld` is never high on two consecutive clocks. The distance between two strobes is `OVS`-1, `OVS` or `OVS`+1 clocks, so the sampling phase moves by at most one clock per bit period.
- R4: Once the block is locked, the recovered bits are the transmitted bits at one fixed offset, with none lost or repeated. This holds for a steady stream, for a transmitter that is slowly faster, and for one that is slowly slower (one bit in 25 lasting `OVS`-1 or `OVS`+1 clocks).
- R5: Transitions are binned by timer position over windows of `WIN` bits. The sampling instant converges to the position opposite the most populated bin, so that from bit 40 onward (five windows at the defaults) a single alignment offset between sent and recovered bits exists.
- R6: `err` rises once no transition has been seen for more than `IDLE_LIM` (64) bit periods, and stays low for a quiet stretch of about 60 bit periods.
- R7: `err` is high after a window in which transitions fell into more than `OVS`/2 distinct timer positions.
- R8: `err` returns low once a clean stream resumes: the quiet counter clears on the first transition, and the next window with clustered transitions clears the scatter condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, `OVS` times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Asynchronous serial line |
| bit_out | output | 1 | Recovered bit, valid when `bit_vld` is high |
| bit_vld | output | 1 | One-clock strobe per recovered bit |
| err | output | 1 | No consistent bit stream found |

## Verification
The window-end decision and the bit strobe always land on the same clock, because the window boundary is a strobe. That clock may also carry a transition, which must be counted in the fresh window while the phase step reshapes the very period being reloaded. Drifting streams, where one bit in 25 is a clock short or long, force these coincidences repeatedly. They are judged by requiring one alignment offset across hundreds of recovered bits and a strobe spacing that never leaves the one-clock band.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    // Length change applied to the bit period that follows a window decision
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;

endpackage

// File: rtl/cdr_insync.sv
module cdr_insync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic smp,
    output logic edge_seen
);

    typedef struct packed {
        logic [SYNC_N-1:0] sh;
        logic              prev;
    } sy_t;

    sy_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.sh   = {r_q.sh[SYNC_N-2:0], line_in};
        r_d.prev = r_q.sh[SYNC_N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign smp       = r_q.sh[SYNC_N-1];
    assign edge_seen = r_q.sh[SYNC_N-1] ^ r_q.prev;

endmodule

// File: rtl/cdr_edge_hist.sv
module cdr_edge_hist #(
    parameter int OVS   = 5,
    parameter int PW    = 3,
    parameter int CNT_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_seen,
    input  logic [PW-1:0] pos,
    input  logic          win_end,
    output logic [PW-1:0] best_pos,
    output logic          any_edge,
    output logic [PW:0]   bins_used
);

    logic [OVS-1:0][CNT_W-1:0] bin_q, bin_d;
    logic [CNT_W-1:0]          top_c;

    // one saturating counter per timer position; cleared at a window end,
    // where an edge in the same clock opens the new window with a count of 1
    for (genvar g = 0; g < OVS; g++) begin : g_bin
        logic hit;
        assign hit = edge_seen && (pos == PW'(g));
        assign bin_d[g] = win_end ? (hit ? CNT_W'(1) : '0)
                        : ((hit && (bin_q[g] != '1)) ? bin_q[g] + 1'b1 : bin_q[g]);
    end

    always_comb begin
        best_pos  = '0;
        top_c     = '0;
        bins_used = '0;
        for (int i = 0; i < OVS; i++) begin
            if (bin_q[i] > top_c) begin
                top_c    = bin_q[i];
                best_pos = PW'(i);
            end
            if (bin_q[i] != '0) bins_used = bins_used + 1'b1;
        end
    end

    assign any_edge = (top_c != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_d;
    end

    // checker: largest bin found by an independent scan
    logic [CNT_W-1:0] chk_max;
    always_comb begin
        chk_max = '0;
        for (int i = 0; i < OVS; i++)
            if (bin_q[i] >= chk_max) chk_max = bin_q[i];
    end

    assert_best_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && any_edge) |-> (bin_q[best_pos] == chk_max));

    assert_window_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_end) && !$past(edge_seen)) |-> (bin_q == '0));

endmodule

// File: rtl/cdr_phase_trk.sv
module cdr_phase_trk
    import cdr_pkg::*;
#(
    parameter int OVS      = 5,
    parameter int WIN      = 8,
    parameter int IDLE_LIM = 64,
    parameter int PW       = 3,
    parameter int TW       = 3,
    parameter int WW       = 3,
    parameter int IW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp,
    input  logic          edge_seen,
    input  logic [PW-1:0] best_pos,
    input  logic          any_edge,
    input  logic [PW:0]   bins_used,
    output logic [PW-1:0] pos,
    output logic          win_end,
    output logic          bit_out,
    output logic          bit_vld,
    output logic          err
);

    localparam int HALF = OVS / 2;
    localparam int BW   = PW + 1;
    localparam int GW   = TW + 1;

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [WW-1:0] win;
        logic [IW-1:0] idle;
        logic          spread;
        logic          bitv;
        logic          vld;
        logic          err;
    } trk_t;

    trk_t r_q, r_d;
    adj_e adj;
    logic strobe;

    assign strobe  = (r_q.tmr == '0);
    assign win_end = strobe && (r_q.win == WW'(WIN - 1));
    assign pos     = (r_q.tmr > TW'(OVS - 1)) ? PW'(OVS - 1) : PW'(r_q.tmr);

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        adj     = ADJ_NONE;
        if (win_end && any_edge) begin
            if (best_pos > PW'(HALF))      adj = ADJ_SHORT;
            else if (best_pos < PW'(HALF)) adj = ADJ_LONG;
        end
        if (strobe) begin
            r_d.vld  = 1'b1;
            r_d.bitv = smp;
            r_d.win  = win_end ? '0 : r_q.win + 1'b1;
            case (adj)
                ADJ_SHORT: r_d.tmr = TW'(OVS - 2);
                ADJ_LONG:  r_d.tmr = TW'(OVS);
                default:   r_d.tmr = TW'(OVS - 1);
            endcase
            if (win_end) r_d.spread = (bins_used > BW'(HALF));
        end else begin
            r_d.tmr = r_q.tmr - 1'b1;
        end
        if (edge_seen)
            r_d.idle = '0;
        else if (strobe && (r_q.idle <= IW'(IDLE_LIM)))
            r_d.idle = r_q.idle + 1'b1;
        r_d.err = r_d.spread | (r_d.idle > IW'(IDLE_LIM));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.tmr <= TW'(OVS - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_out = r_q.bitv;
    assign bit_vld = r_q.vld;
    assign err     = r_q.err;

    // checker: clocks between strobes
    logic [GW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (bit_vld) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld);

    assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && bit_vld) |-> ((gap_q >= GW'(OVS - 2)) && (gap_q <= GW'(OVS))));

endmodule

// File: rtl/cdr_blind_os.sv
module cdr_blind_os #(
    parameter int OVS      = 5,
    parameter int WIN      = 8,
    parameter int IDLE_LIM = 64,
    parameter int SYNC_N   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_out,
    output logic bit_vld,
    output logic err
);

    localparam int PW    = $clog2(OVS);
    localparam int TW    = $clog2(OVS + 1);
    localparam int WW    = $clog2(WIN);
    localparam int IW    = $clog2(IDLE_LIM + 2);
    localparam int CNT_W = $clog2(WIN + 1);

    logic          smp, edge_seen, win_end, any_edge;
    logic [PW-1:0] pos, best_pos;
    logic [PW:0]   bins_used;

    cdr_insync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .smp(smp), .edge_seen(edge_seen)
    );

    cdr_edge_hist #(.OVS(OVS), .PW(PW), .CNT_W(CNT_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .pos(pos),
        .win_end(win_end), .best_pos(best_pos), .any_edge(any_edge),
        .bins_used(bins_used)
    );

    cdr_phase_trk #(
        .OVS(OVS), .WIN(WIN), .IDLE_LIM(IDLE_LIM),
        .PW(PW), .TW(TW), .WW(WW), .IW(IW)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .smp(smp), .edge_seen(edge_seen),
        .best_pos(best_pos), .any_edge(any_edge), .bins_used(bins_used),
        .pos(pos), .win_end(win_end), .bit_out(bit_out),
        .bit_vld(bit_vld), .err(err)
    );

    // checker: a line quiet far beyond the idle limit must show an error
    localparam int QLIM = (IDLE_LIM + 2) * (OVS + 1) + 8;
    logic [31:0] quiet_q;
    logic        lprev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
            lprev_q <= 1'b0;
        end else begin
            lprev_q <= line_in;
            if (line_in != lprev_q)   quiet_q <= '0;
            else if (quiet_q != '1)   quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_idle_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q > 32'(QLIM)) |-> err);

endmodule

// File: tb/sim_cdr_blind_os.sv
module sim_cdr_blind_os;

    localparam int OVS = 5;
    localparam int NB  = 1024;
    // mode, bits, min gap, max gap, expected mismatches
    localparam int TBL [3][5] = '{
        '{0, 300, 5, 5, 0},
        '{1, 400, 4, 5, 0},
        '{2, 400, 5, 6, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic bit_out, bit_vld, err;

    always #2 clk = ~clk;

    cdr_blind_os u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .bit_out(bit_out), .bit_vld(bit_vld), .err(err)
    );

    int nchk = 0, nerr = 0;
    logic tx_hist [NB];
    logic rx_hist [NB];
    int tx_n = 0, rx_n = 0;
    bit rec_on = 1'b0;
    int cyc = 0, last_t = 0, gmin = 1000, gmax = 0;
    int vld_cnt = 0, c0 = 0, c1 = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && bit_vld) vld_cnt++;
        if (rec_on && bit_vld && rx_n < NB) begin
            if (rx_n >= 40) begin
                if (cyc - last_t < gmin) gmin = cyc - last_t;
                if (cyc - last_t > gmax) gmax = cyc - last_t;
            end
            last_t = cyc;
            rx_hist[rx_n] = bit_out;
            rx_n++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic do_reset();
        rec_on  = 1'b0;
        rst_n   = 1'b0;
        line_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 bit_out in reset", int'(bit_out), 0);
        check("R1 bit_vld in reset", int'(bit_vld), 0);
        check("R1 err in reset", int'(err), 0);
        tx_n = 0; rx_n = 0; gmin = 1000; gmax = 0;
        rst_n  = 1'b1;
        rec_on = 1'b1;
    endtask

    task automatic send_bits(input int nbits, input int mode);
        for (int b = 0; b < nbits; b++) begin
            int per;
            line_in = lfsr[0];
            if (tx_n < NB) begin
                tx_hist[tx_n] = lfsr[0];
                tx_n++;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            per = OVS;
            if (mode == 1 && (b % 25) == 24) per = OVS - 1;
            if (mode == 2 && (b % 25) == 24) per = OVS + 1;
            if (b == 100) c0 = vld_cnt;
            if (b == 120) c1 = vld_cnt;
            repeat (per) @(negedge clk);
        end
    endtask

    task automatic judge(input int gmin_e, input int gmax_e, input int mis_e);
        int k, mis;
        bit found;
        found = 1'b0;
        k = 0;
        for (int kk = -4; kk <= 4 && !found; kk++) begin
            bit ok = 1'b1;
            for (int j = 40; j < 72; j++)
                if (j + kk < 0 || j + kk >= tx_n || rx_hist[j] !== tx_hist[j + kk]) ok = 1'b0;
            if (ok) begin found = 1'b1; k = kk; end
        end
        check("R5 single alignment offset found", int'(found), 1);
        mis = 0;
        for (int j = 40; j < rx_n; j++)
            if (j + k < tx_n && rx_hist[j] !== tx_hist[j + k]) mis++;
        check("R4 recovered bit mismatches", mis, mis_e);
        check("R4 no lost or repeated bits", int'((rx_n + k - tx_n) <= 3 && (tx_n - rx_n - k) <= 3), 1);
        check("R3 min strobe gap", gmin, gmin_e);
        check("R3 max strobe gap", gmax, gmax_e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // table-driven streams: steady, fast transmitter, slow transmitter
        for (int s = 0; s < 3; s++) begin
            do_reset();
            send_bits(TBL[s][1], TBL[s][0]);
            rec_on = 1'b0;
            judge(TBL[s][2], TBL[s][3], TBL[s][4]);
            if (TBL[s][0] == 0) begin
                check("R2 strobes in 100 clocks", c1 - c0, 20);
                check("R8 err low on clean stream", int'(err), 0);
            end
        end

        // error flag: scatter, quiet boundary, long quiet, recovery
        do_reset();
        send_bits(60, 0);
        for (int c = 0; c < 150; c++) begin
            if (c % 3 == 0) line_in = ~line_in;
            @(negedge clk);
        end
        check("R7 err after scattered edges", int'(err), 1);
        repeat (300) @(negedge clk);
        check("R6 err low after 60 quiet periods", int'(err), 0);
        repeat (250) @(negedge clk);
        check("R6 err high after 110 quiet periods", int'(err), 1);
        send_bits(40, 0);
        check("R8 err clears after clean data", int'(err), 0);

        summary();
        $finish;
    end

endmodule